// File: doc/BRIEF.md
# Multi-Expiration Watchdog Timer

This block is a watchdog whose total timeout is split into five equal periods. Software programs one period, and a down counter counts it off one tick at a time. Each time the counter runs out, it reloads the period and an expiration counter moves up by one. Only the fifth expiration drives the system reset. A single lost kick therefore does not reset the system. Software can still work out the time left from two values: the live down-counter value and the number of expirations so far.

The counter advances only on cycles where the selected tick input is high. The tick inputs are one-per-microsecond enables, and a control field picks one of them. Software reaches the block through a small word-addressed register port:

| Word | Register | Contents |
|------|----------|----------|
| 0 | control | tick source select and interrupt enable |
| 1 | period | reload value |
| 2 | command | start, stop and kick |
| 3 | watchdog status | running flag and expiration count |
| 4 | timer status | live count, interrupt pending, write-one-to-clear |

The first expiration can raise a local interrupt, which gives software an early warning. The system reset is a single-cycle pulse. The same pulse returns the whole block to its reset state.

Top module: `wdg_multi_expiry`

## Requirements
- R1: After rst_i, the watchdog is stopped, every readable register reads 0, and sys_rst_o and irq_o are low.
- R2: The live count and the expiration count change only on a cycle where the watchdog is running and the selected tick input is high. While the watchdog is stopped, ticks leave both values frozen.
- R3: A tick that finds the live count at 1 or 0 is an expiration. It reloads the period and adds one to the expiration count, read at watchdog status bits 14:12. Each expiration spans max(period,1) ticks.
- R4: The fifth expiration gives exactly one cycle of sys_rst_o, in the cycle after that tick. Afterwards every register, the control and period included, reads as after rst_i.
- R5: Command word 2 bit 0 starts the watchdog: it loads the period, clears the expiration count and sets the running flag (watchdog status bit 0). Bit 1 stops it, and stop wins when both bits are written together. Stopping and then starting again clears the expiration count.
- R6: Command bit 2 (kick) reloads the period and clears the expiration count while the watchdog runs. While the watchdog is stopped, a kick changes nothing.
- R7: If control bit 4 is set, the first expiration sets irq_o, which also reads as timer status bit 30. Later expirations do not set it. It stays set until software writes 1 to timer status bit 30.
- R8: Control bits 3:0 select which bit of tick_src_i is the tick. A select value of SRC_N or more gives no ticks at all.
- R9: rdata_o shows, one cycle after addr_i is applied, the register at that address: live count in timer status bits 28:0, control and period as written, command reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | clock |
| rst_i | input | 1 | synchronous active-high reset |
| tick_src_i | input | SRC_N | candidate microsecond tick enables |
| wr_en_i | input | 1 | register write strobe |
| addr_i | input | 3 | register word address |
| wdata_i | input | 32 | register write data |
| rdata_o | output | 32 | registered read data |
| irq_o | output | 1 | first-expiration interrupt, level |
| sys_rst_o | output | 1 | system reset pulse on fifth expiration |

## Verification
Some checks run on every cycle:
- the expiration count stays in range;
- the count holds when no tick arrives;
- each expiration steps the count by exactly one;
- a kick reloads the counter;
- the interrupt sets on the first expiration;
- sys_rst_o lasts exactly one cycle and leaves the watchdog stopped.

Other behaviour only the bench scenarios can show: the exact tick on which the fifth expiration fires, the full restoration of the configuration after that pulse, and the tick-source selection, including out-of-range codes. The bench also shows the command priorities, a kick given while the watchdog is stopped, and the interrupt clear.

// File: rtl/wdg_pkg.sv
package wdg_pkg;

  localparam int DATA_W = 32;
  localparam int ADDR_W = 3;

  // register word addresses
  localparam logic [ADDR_W-1:0] ADR_CTRL   = 3'd0;
  localparam logic [ADDR_W-1:0] ADR_PERIOD = 3'd1;
  localparam logic [ADDR_W-1:0] ADR_CMD    = 3'd2;
  localparam logic [ADDR_W-1:0] ADR_WSTAT  = 3'd3;
  localparam logic [ADDR_W-1:0] ADR_TSTAT  = 3'd4;

  // bit positions
  localparam int CTRL_IRQEN_BIT   = 4;
  localparam int CMD_START_BIT    = 0;
  localparam int CMD_STOP_BIT     = 1;
  localparam int CMD_KICK_BIT     = 2;
  localparam int WSTAT_RUN_BIT    = 0;
  localparam int WSTAT_EXP_LSB    = 12;
  localparam int TSTAT_IRQ_BIT    = 30;

  typedef struct packed {
    logic start;
    logic stop;
    logic kick;
  } wdg_cmd_t;

endpackage

// File: rtl/wdg_tick_sel.sv
module wdg_tick_sel #(
  parameter int SRC_N = 4,
  parameter int SEL_W = 4
) (
  input  logic [SRC_N-1:0] src_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             tick_o
);

  logic [SRC_N-1:0] hit;

  // one comparator per source; codes past the last source match nothing
  for (genvar g = 0; g < SRC_N; g++) begin : g_src
    assign hit[g] = (sel_i == SEL_W'(g)) && src_i[g];
  end

  assign tick_o = |hit;

endmodule

// File: rtl/wdg_regif.sv
module wdg_regif
  import wdg_pkg::*;
#(
  parameter int CNT_W = 29,
  parameter int EXP_W = 3,
  parameter int SEL_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [SEL_W-1:0]  src_sel_o,
  output logic              irq_en_o,
  output logic [CNT_W-1:0]  period_o,
  output wdg_cmd_t          cmd_o,
  output logic              irq_clr_o,
  input  logic              run_i,
  input  logic [EXP_W-1:0]  exp_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic              irq_i
);

  logic [SEL_W-1:0]  src_sel_q;
  logic              irq_en_q;
  logic [CNT_W-1:0]  period_q;
  logic [DATA_W-1:0] rd_next;
  logic              wr_cmd;
  logic              wr_tstat;
  logic              unused_wdata;

  assign wr_cmd   = wr_en_i && (addr_i == ADR_CMD);
  assign wr_tstat = wr_en_i && (addr_i == ADR_TSTAT);

  assign cmd_o.start = wr_cmd && wdata_i[CMD_START_BIT];
  assign cmd_o.stop  = wr_cmd && wdata_i[CMD_STOP_BIT];
  assign cmd_o.kick  = wr_cmd && wdata_i[CMD_KICK_BIT];
  assign irq_clr_o   = wr_tstat && wdata_i[TSTAT_IRQ_BIT];

  assign unused_wdata = ^wdata_i;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      src_sel_q <= '0;
      irq_en_q  <= 1'b0;
      period_q  <= '0;
    end else if (wr_en_i) begin
      if (addr_i == ADR_CTRL) begin
        src_sel_q <= wdata_i[SEL_W-1:0];
        irq_en_q  <= wdata_i[CTRL_IRQEN_BIT];
      end
      if (addr_i == ADR_PERIOD) begin
        period_q <= wdata_i[CNT_W-1:0];
      end
    end
  end

  always_comb begin
    rd_next = '0;
    case (addr_i)
      ADR_CTRL: begin
        rd_next[SEL_W-1:0]     = src_sel_q;
        rd_next[CTRL_IRQEN_BIT] = irq_en_q;
      end
      ADR_PERIOD: rd_next[CNT_W-1:0] = period_q;
      ADR_WSTAT: begin
        rd_next[WSTAT_RUN_BIT]             = run_i;
        rd_next[WSTAT_EXP_LSB +: EXP_W]    = exp_i;
      end
      ADR_TSTAT: begin
        rd_next[CNT_W-1:0]     = cnt_i;
        rd_next[TSTAT_IRQ_BIT] = irq_i;
      end
      default: rd_next = '0;
    endcase
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) rdata_o <= '0;
    else       rdata_o <= rd_next;
  end

  assign src_sel_o = src_sel_q;
  assign irq_en_o  = irq_en_q;
  assign period_o  = period_q;

  AST_CMD_NO_WRITE: assert property (@(posedge clk_i) disable iff (rst_i)
    !wr_en_i |-> (cmd_o == '0) && !irq_clr_o); // R5

endmodule

// File: rtl/wdg_count_core.sv
module wdg_count_core
  import wdg_pkg::*;
#(
  parameter int CNT_W     = 29,
  parameter int EXPIRY_N  = 5,
  parameter int EXP_W     = 3
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             tick_i,
  input  wdg_cmd_t         cmd_i,
  input  logic [CNT_W-1:0] period_i,
  input  logic             irq_en_i,
  input  logic             irq_clr_i,
  output logic             run_o,
  output logic [EXP_W-1:0] exp_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             irq_o,
  output logic             sys_rst_o
);

  localparam logic [EXP_W-1:0] EXP_LAST = EXP_W'(EXPIRY_N - 1);

  logic             run_q;
  logic [CNT_W-1:0] cnt_q;
  logic [EXP_W-1:0] exp_q;
  logic             irq_q;
  logic             sysrst_q;
  logic             count_ok;
  logic             expire;
  logic             last_exp;

  assign count_ok = run_q && tick_i && !cmd_i.stop && !cmd_i.start && !cmd_i.kick;
  assign expire   = count_ok && (cnt_q <= CNT_W'(1));
  assign last_exp = (exp_q == EXP_LAST);

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      run_q    <= 1'b0;
      cnt_q    <= '0;
      exp_q    <= '0;
      sysrst_q <= 1'b0;
    end else begin
      sysrst_q <= 1'b0;
      if (cmd_i.stop) begin
        run_q <= 1'b0;
      end else if (cmd_i.start) begin
        run_q <= 1'b1;
        cnt_q <= period_i;
        exp_q <= '0;
      end else if (run_q && cmd_i.kick) begin
        cnt_q <= period_i;
        exp_q <= '0;
      end else if (expire) begin
        cnt_q <= period_i;
        if (last_exp) begin
          sysrst_q <= 1'b1;
          run_q    <= 1'b0;
        end else begin
          exp_q <= exp_q + EXP_W'(1);
        end
      end else if (count_ok) begin
        cnt_q <= cnt_q - CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      irq_q <= 1'b0;
    end else if (expire && (exp_q == '0) && irq_en_i) begin
      irq_q <= 1'b1;
    end else if (irq_clr_i) begin
      irq_q <= 1'b0;
    end
  end

  assign run_o     = run_q;
  assign exp_o     = exp_q;
  assign cnt_o     = cnt_q;
  assign irq_o     = irq_q;
  assign sys_rst_o = sysrst_q;

  AST_EXP_RANGE: assert property (@(posedge clk_i) disable iff (rst_i)
    exp_q <= EXP_LAST); // R3

  AST_IDLE_FROZEN: assert property (@(posedge clk_i) disable iff (rst_i)
    (!run_q && !cmd_i.start) |=> $stable(cnt_q) && $stable(exp_q)); // R2

  AST_NO_TICK_HOLD: assert property (@(posedge clk_i) disable iff (rst_i)
    (run_q && !tick_i && (cmd_i == '0)) |=> $stable(cnt_q) && $stable(exp_q)); // R2

  AST_EXP_STEP: assert property (@(posedge clk_i) disable iff (rst_i)
    (expire && !last_exp) |=> (exp_q == $past(exp_q) + EXP_W'(1)) && (cnt_q == $past(period_i))); // R3

  AST_KICK_RELOAD: assert property (@(posedge clk_i) disable iff (rst_i)
    (run_q && cmd_i.kick && !cmd_i.stop && !cmd_i.start) |=> (exp_q == '0) && (cnt_q == $past(period_i))); // R6

  AST_IRQ_FIRST: assert property (@(posedge clk_i) disable iff (rst_i)
    (expire && (exp_q == '0) && irq_en_i) |=> irq_q); // R7

endmodule

// File: rtl/wdg_multi_expiry.sv
module wdg_multi_expiry
  import wdg_pkg::*;
#(
  parameter int CNT_W    = 29,
  parameter int EXPIRY_N = 5,
  parameter int SRC_N    = 4,
  parameter int SEL_W    = 4
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic [SRC_N-1:0]  tick_src_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o,
  output logic              sys_rst_o
);

  localparam int EXP_W = $clog2(EXPIRY_N);

  logic             blk_rst;
  logic             tick;
  logic [SEL_W-1:0] src_sel;
  logic             irq_en;
  logic [CNT_W-1:0] period;
  wdg_cmd_t         cmd;
  logic             irq_clr;
  logic             run;
  logic [EXP_W-1:0] exp_cnt;
  logic [CNT_W-1:0] cnt;
  logic             irq;
  logic             sys_rst;

  // the fifth-expiry pulse doubles as a block-wide reset
  assign blk_rst = rst_i | sys_rst;

  wdg_tick_sel #(.SRC_N(SRC_N), .SEL_W(SEL_W)) u_tick_sel (
    .src_i  (tick_src_i),
    .sel_i  (src_sel),
    .tick_o (tick)
  );

  wdg_regif #(.CNT_W(CNT_W), .EXP_W(EXP_W), .SEL_W(SEL_W)) u_regif (
    .clk_i     (clk_i),
    .rst_i     (blk_rst),
    .wr_en_i   (wr_en_i),
    .addr_i    (addr_i),
    .wdata_i   (wdata_i),
    .rdata_o   (rdata_o),
    .src_sel_o (src_sel),
    .irq_en_o  (irq_en),
    .period_o  (period),
    .cmd_o     (cmd),
    .irq_clr_o (irq_clr),
    .run_i     (run),
    .exp_i     (exp_cnt),
    .cnt_i     (cnt),
    .irq_i     (irq)
  );

  wdg_count_core #(.CNT_W(CNT_W), .EXPIRY_N(EXPIRY_N), .EXP_W(EXP_W)) u_core (
    .clk_i     (clk_i),
    .rst_i     (blk_rst),
    .tick_i    (tick),
    .cmd_i     (cmd),
    .period_i  (period),
    .irq_en_i  (irq_en),
    .irq_clr_i (irq_clr),
    .run_o     (run),
    .exp_o     (exp_cnt),
    .cnt_o     (cnt),
    .irq_o     (irq),
    .sys_rst_o (sys_rst)
  );

  assign irq_o     = irq;
  assign sys_rst_o = sys_rst;

  AST_RST_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (rst_i)
    sys_rst_o |=> !sys_rst_o); // R4

  AST_RST_STOPS: assert property (@(posedge clk_i) disable iff (rst_i)
    sys_rst_o |=> !run && !irq_o); // R4

  AST_OUT_OF_RANGE_SRC: assert property (@(posedge clk_i) disable iff (rst_i)
    (src_sel >= SEL_W'(SRC_N)) |-> !tick); // R8

endmodule

// File: tb/test_wdg_multi_expiry.sv
`timescale 1ns/1ps
module test_wdg_multi_expiry;

  localparam int SRC_N = 4;

  logic             clk = 1'b0;
  logic             rst;
  logic [SRC_N-1:0] tick_src;
  logic             wr_en;
  logic [2:0]       addr;
  logic [31:0]      wdata;
  logic [31:0]      rdata;
  logic             irq;
  logic             sys_rst;

  int total = 0;
  int bad   = 0;
  int pulses = 0;
  bit timed_out = 0;

  always #4 clk = ~clk;

  wdg_multi_expiry #(.SRC_N(SRC_N)) i_wdg_multi_expiry (
    .clk_i      (clk),
    .rst_i      (rst),
    .tick_src_i (tick_src),
    .wr_en_i    (wr_en),
    .addr_i     (addr),
    .wdata_i    (wdata),
    .rdata_o    (rdata),
    .irq_o      (irq),
    .sys_rst_o  (sys_rst)
  );

  always @(negedge clk) if (sys_rst) pulses++;

  // period, ticks, expected expirations, expected live count
  localparam int VTAB [6][4] = '{
    '{10,  0, 0, 10},
    '{10,  3, 0,  7},
    '{10, 10, 1, 10},
    '{ 7, 20, 2,  1},
    '{ 3, 14, 4,  1},
    '{ 1,  4, 4,  1}
  };

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0; wdata = '0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a;
    @(negedge clk);
    d = rdata;
  endtask

  task automatic tick(input int n, input logic [SRC_N-1:0] mask);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      tick_src = mask;
      @(negedge clk);
      tick_src = '0;
    end
  endtask

  task automatic run_all();
    logic [31:0] v;
    // R1 reset state
    rd(3'd0, v); check("R1 ctrl", v, 0);
    rd(3'd1, v); check("R1 period", v, 0);
    rd(3'd3, v); check("R1 wstat", v, 0);
    rd(3'd4, v); check("R1 tstat", v, 0);
    check("R1 sys_rst", {31'd0, sys_rst}, 0);
    check("R1 irq", {31'd0, irq}, 0);

    // R3 R9 vector table
    for (int i = 0; i < 6; i++) begin
      wr(3'd2, 32'h2);
      wr(3'd1, VTAB[i][0]);
      wr(3'd2, 32'h1);
      tick(VTAB[i][1], 4'b0001);
      rd(3'd3, v); check("R3 table wstat", v, (VTAB[i][2] << 12) | 1);
      rd(3'd4, v); check("R9 table tstat", v, VTAB[i][3]);
    end
    rd(3'd1, v); check("R9 period readback", v, 1);
    rd(3'd2, v); check("R9 cmd reads zero", v, 0);

    // R3 period zero: every tick expires
    wr(3'd2, 32'h2); wr(3'd1, 0); wr(3'd2, 32'h1);
    tick(2, 4'b0001);
    rd(3'd3, v); check("R3 period0 wstat", v, (2 << 12) | 1);
    rd(3'd4, v); check("R3 period0 tstat", v, 0);

    // R2 R5 R6 stop freezes, kick while stopped ignored, restart clears
    wr(3'd2, 32'h2); wr(3'd1, 2); wr(3'd2, 32'h1);
    tick(3, 4'b0001);
    wr(3'd2, 32'h2);
    tick(2, 4'b0001);
    rd(3'd4, v); check("R2 stopped count", v, 1);
    rd(3'd3, v); check("R2 stopped wstat", v, 1 << 12);
    wr(3'd1, 9);
    wr(3'd2, 32'h4);
    rd(3'd4, v); check("R6 kick stopped count", v, 1);
    rd(3'd3, v); check("R6 kick stopped wstat", v, 1 << 12);
    wr(3'd2, 32'h1);
    rd(3'd3, v); check("R5 restart wstat", v, 1);
    rd(3'd4, v); check("R5 restart count", v, 9);
    wr(3'd2, 32'h3);
    rd(3'd3, v); check("R5 stop wins", v, 0);

    // R6 kick while running
    wr(3'd1, 5); wr(3'd2, 32'h1);
    tick(7, 4'b0001);
    rd(3'd3, v); check("R6 pre-kick wstat", v, (1 << 12) | 1);
    wr(3'd2, 32'h4);
    rd(3'd3, v); check("R6 kick wstat", v, 1);
    rd(3'd4, v); check("R6 kick count", v, 5);

    // R8 source select
    wr(3'd2, 32'h2); wr(3'd0, 32'h2); wr(3'd1, 10); wr(3'd2, 32'h1);
    tick(3, 4'b0001);
    rd(3'd4, v); check("R8 wrong source", v, 10);
    tick(3, 4'b0100);
    rd(3'd4, v); check("R8 selected source", v, 7);
    wr(3'd0, 32'h9);
    tick(2, 4'b1111);
    rd(3'd4, v); check("R8 out of range select", v, 7);
    rd(3'd0, v); check("R9 ctrl readback", v, 9);

    // R7 interrupt
    wr(3'd2, 32'h2); wr(3'd0, 32'h10); wr(3'd1, 3); wr(3'd2, 32'h1);
    tick(2, 4'b0001);
    check("R7 irq before expiry", {31'd0, irq}, 0);
    tick(1, 4'b0001);
    check("R7 irq on first", {31'd0, irq}, 1);
    rd(3'd4, v); check("R7 tstat irq bit", v, (1 << 30) | 3);
    tick(3, 4'b0001);
    check("R7 irq held", {31'd0, irq}, 1);
    wr(3'd4, 32'h4000_0000);
    check("R7 irq cleared", {31'd0, irq}, 0);
    tick(3, 4'b0001);
    check("R7 no irq later expiry", {31'd0, irq}, 0);
    wr(3'd2, 32'h2); wr(3'd0, 32'h0); wr(3'd1, 1); wr(3'd2, 32'h1);
    tick(1, 4'b0001);
    check("R7 irq disabled", {31'd0, irq}, 0);

    // R4 fifth expiration
    wr(3'd2, 32'h2); wr(3'd0, 32'h10); wr(3'd1, 2); wr(3'd2, 32'h1);
    pulses = 0;
    tick(9, 4'b0001);
    check("R4 no reset before fifth", pulses, 0);
    rd(3'd3, v); check("R4 four expirations", v, (4 << 12) | 1);
    tick(1, 4'b0001);
    check("R4 reset pulse", {31'd0, sys_rst}, 1);
    @(negedge clk);
    check("R4 pulse single cycle", {31'd0, sys_rst}, 0);
    check("R4 pulse count", pulses, 1);
    rd(3'd0, v); check("R4 ctrl restored", v, 0);
    rd(3'd1, v); check("R4 period restored", v, 0);
    rd(3'd3, v); check("R4 wstat restored", v, 0);
    rd(3'd4, v); check("R4 tstat restored", v, 0);
    check("R4 irq restored", {31'd0, irq}, 0);
  endtask

  initial begin
    rst = 1'b1; tick_src = '0; wr_en = 1'b0; addr = '0; wdata = '0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    fork
      run_all();
      begin
        repeat (100000) @(posedge clk);
        timed_out = 1;
      end
    join_any
    disable fork;
    if (timed_out) begin
      total++; bad++;
      $display("FAIL watchdog R1..: got=hung exp=done");
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule